// File: doc/BRIEF.md
# Serial Byte Receiver with Three-Wire and Four-Wire Framing

This block is the write-only serial front end of a display controller. A host drives a chip select (active low), a serial clock and a serial data line. While chip select is low, the block samples the data line on every rising edge of the serial clock, most significant bit first, and collects whole bytes. Each finished byte leaves the block as a one-cycle valid pulse together with the byte and a flag that tells display-memory data apart from a command.

Two framings are supported, picked by a mode pin. In four-wire framing a frame is eight bits long and a separate tag pin gives the data/command meaning. In three-wire framing the tag travels in-band as a leading ninth bit, and a polarity pin decides which value of that bit means display data. All serial pins are asynchronous to the block clock; they are resynchronised and the serial clock edge is found by oversampling, so the serial clock must run several times slower than the block clock. Nothing can be read back over this link.

Top module: `serial_cmd_rx`

## Requirements
- R1: After reset, byte_vld is 0, byte_out is 0x00 and byte_is_data is 0.
- R2: The data line is sampled on each rising serial clock edge while cs_n is low, and the first bit sampled after the tag (if any) lands in byte_out bit 7, the last in bit 0.
- R3: With wire3_sel = 0, a frame is complete on the 8th rising edge; byte_is_data equals the level of the rs pin at that edge (1 = display data, 0 = command).
- R4: With wire3_sel = 1, a frame is 9 bits: the first sampled bit is the tag, the next eight are the byte, and the frame completes on the 9th rising edge.
- R5: With wire3_sel = 1, byte_is_data is 1 when the tag bit equals rs_pol and 0 otherwise (rs_pol = 0: tag 0 is data; rs_pol = 1: tag 1 is data).
- R6: While cs_n is high the bit counter and shift register stay cleared: serial clock edges are ignored, and raising cs_n in mid-frame drops the partial byte with no valid pulse; the next frame starts from bit one.
- R7: The bit counter wraps after each complete frame, so consecutive frames are received with cs_n held low throughout.
- R8: byte_vld is high for exactly one clock per completed frame; byte_out and byte_is_data hold their values until the next frame completes.
- R9: With wire3_sel = 1 the rs pin has no effect on byte_is_data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Serial chip select, active low, asynchronous |
| scl | input | 1 | Serial clock, asynchronous |
| sda | input | 1 | Serial data, asynchronous |
| rs | input | 1 | Data/command tag pin used in four-wire framing |
| wire3_sel | input | 1 | Framing select: 0 = four-wire, 1 = three-wire |
| rs_pol | input | 1 | Tag polarity for three-wire framing |
| byte_vld | output | 1 | One-cycle pulse per received byte |
| byte_out | output | 8 | Last received byte |
| byte_is_data | output | 1 | 1 = display data, 0 = command |

## Verification
The assertions assume the serial clock high and low phases each last longer than the synchroniser depth plus one block clock, so each serial clock rise is seen exactly once, and that sda, rs, wire3_sel and rs_pol are steady around each rising edge. The stimulus holds every serial phase for four block clocks, changes sda and rs only while the serial clock is low, and changes the framing and polarity pins only while cs_n is high. Under those conditions the checks on the counter bound, single-cycle pulses and held outputs follow from the framing rules alone.

// File: rtl/srx_pkg.sv
package srx_pkg;
   typedef enum logic {
      FRAME_4W = 1'b0,
      FRAME_3W = 1'b1
   } frame_mode_e;

   // Meaning of the raw tag bit for a given framing and polarity.
   function automatic logic tag_is_data(frame_mode_e mode, logic tag, logic pol);
      if (mode == FRAME_3W) return (tag == pol);
      return tag;
   endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   input  logic [WIDTH-1:0] reset_val,
   output logic [WIDTH-1:0] sync_out
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("srx_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("srx_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= reset_val;
            else if (s == 0) chain[s] <= async_in;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter
   import srx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_s,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              rs_s,
   input  frame_mode_e       mode_s,
   output logic              frm_vld,
   output logic [DATA_W-1:0] frm_byte,
   output logic              frm_tag
);
   localparam int CNT_W = $clog2(DATA_W + 2);
   localparam logic [CNT_W-1:0] LAST_4W = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] LAST_3W = CNT_W'(DATA_W);

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("srx_shifter: DATA_W must be at least 2");
      end
   endgenerate

   logic              scl_q;
   logic              scl_rise;
   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-1:0] shreg;
   logic [CNT_W-1:0]  last_idx;

   assign scl_rise = scl_s & ~scl_q;
   assign last_idx = (mode_s == FRAME_3W) ? LAST_3W : LAST_4W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scl_q <= 1'b0;
      else        scl_q <= scl_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         shreg    <= '0;
         frm_vld  <= 1'b0;
         frm_byte <= '0;
         frm_tag  <= 1'b0;
      end else begin
         frm_vld <= 1'b0;
         if (cs_n_s) begin
            bit_cnt <= '0;
            shreg   <= '0;
         end else if (scl_rise) begin
            if (bit_cnt == last_idx) begin
               bit_cnt  <= '0;
               shreg    <= '0;
               frm_vld  <= 1'b1;
               frm_byte <= {shreg[DATA_W-2:0], sda_s};
               frm_tag  <= (mode_s == FRAME_3W) ? shreg[DATA_W-1] : rs_s;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
               shreg   <= {shreg[DATA_W-2:0], sda_s};
            end
         end
      end
   end

   // R7: counter never passes the longest frame
   p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= LAST_3W);
   // R6: deselect clears the frame state
   p_cs_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> (bit_cnt == '0) && !frm_vld);
   // R8: a frame strobe lasts one clock
   p_frm_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frm_vld |=> !frm_vld);
   // R7: after a frame the counter restarts
   p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      frm_vld |-> bit_cnt == '0);
endmodule

// File: rtl/srx_emit.sv
module srx_emit
   import srx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_vld,
   input  logic [DATA_W-1:0] frm_byte,
   input  logic              frm_tag,
   input  frame_mode_e       mode_s,
   input  logic              pol_s,
   output logic              byte_vld,
   output logic [DATA_W-1:0] byte_out,
   output logic              byte_is_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_vld     <= 1'b0;
         byte_out     <= '0;
         byte_is_data <= 1'b0;
      end else begin
         byte_vld <= frm_vld;
         if (frm_vld) begin
            byte_out     <= frm_byte;
            byte_is_data <= tag_is_data(mode_s, frm_tag, pol_s);
         end
      end
   end

   // R8: outputs hold between frames
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_vld |-> $stable(byte_out) && $stable(byte_is_data));
   // R8: valid only follows a completed frame
   p_vld_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |-> $past(frm_vld));
   p_vld_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |=> !byte_vld);
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
   import srx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              scl,
   input  logic              sda,
   input  logic              rs,
   input  logic              wire3_sel,
   input  logic              rs_pol,
   output logic              byte_vld,
   output logic [DATA_W-1:0] byte_out,
   output logic              byte_is_data
);
   localparam int NPIN = 6;
   localparam logic [NPIN-1:0] PIN_RST = NPIN'(6'b000001);

   logic [NPIN-1:0] pins_a, pins_s;
   logic            frm_vld, frm_tag;
   logic [DATA_W-1:0] frm_byte;
   frame_mode_e     mode_s;

   assign pins_a = {rs_pol, wire3_sel, rs, sda, scl, cs_n};
   assign mode_s = frame_mode_e'(pins_s[4]);

   srx_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(pins_a),
      .reset_val(PIN_RST), .sync_out(pins_s));

   srx_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .cs_n_s(pins_s[0]), .scl_s(pins_s[1]),
      .sda_s(pins_s[2]), .rs_s(pins_s[3]), .mode_s(mode_s),
      .frm_vld(frm_vld), .frm_byte(frm_byte), .frm_tag(frm_tag));

   srx_emit #(.DATA_W(DATA_W)) u_emit (
      .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .frm_byte(frm_byte),
      .frm_tag(frm_tag), .mode_s(mode_s), .pol_s(pins_s[5]),
      .byte_vld(byte_vld), .byte_out(byte_out), .byte_is_data(byte_is_data));

   // R6: no byte can appear while deselected long enough to flush the pipe
   p_no_vld_deselected_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pins_s[0]) && $past(pins_s[0], 2) |-> !byte_vld);
endmodule

// File: tb/tb_serial_cmd_rx.sv
module tb_serial_cmd_rx;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, scl = 1'b0, sda = 1'b0, rs = 1'b0;
   logic wire3_sel = 1'b0, rs_pol = 1'b0;
   logic byte_vld, byte_is_data;
   logic [7:0] byte_out;

   int checks = 0, fails = 0;
   int vld_cnt = 0, dbl_vld = 0;
   logic prev_vld = 1'b0;
   logic [7:0] cap_byte = '0;
   logic cap_data = 1'b0;
   bit done = 0;

   always #5 clk = ~clk;

   serial_cmd_rx dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .scl(scl), .sda(sda), .rs(rs),
      .wire3_sel(wire3_sel), .rs_pol(rs_pol), .byte_vld(byte_vld),
      .byte_out(byte_out), .byte_is_data(byte_is_data));

   always @(negedge clk) begin
      if (byte_vld) begin
         vld_cnt++;
         cap_byte = byte_out;
         cap_data = byte_is_data;
         if (prev_vld) dbl_vld++;
      end
      prev_vld = byte_vld;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clock_bits(input logic [8:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         @(negedge clk); sda = v[i];
         idle(4); scl = 1'b1;
         idle(4); scl = 1'b0;
      end
      idle(2);
   endtask

   task automatic frame_end();
      idle(10);
   endtask

   task automatic t_reset();
      chk("R1 byte_vld", byte_vld, 0);
      chk("R1 byte_out", byte_out, 8'h00);
      chk("R1 byte_is_data", byte_is_data, 0);
   endtask

   task automatic t_four_wire();
      int c0;
      wire3_sel = 1'b0; idle(4);
      cs_n = 1'b0; idle(4);
      c0 = vld_cnt; rs = 1'b1;
      clock_bits(9'h0A5, 8); frame_end();
      chk("R3 count", vld_cnt - c0, 1);
      chk("R2 byte msb-first", cap_byte, 8'hA5);
      chk("R3 rs=1 data", cap_data, 1);
      rs = 1'b0;
      clock_bits(9'h03C, 8); frame_end();
      chk("R3 byte", cap_byte, 8'h3C);
      chk("R3 rs=0 command", cap_data, 0);
      chk("R8 hold byte_out", byte_out, 8'h3C);
      cs_n = 1'b1; idle(6);
   endtask

   task automatic t_three_wire();
      int c0;
      wire3_sel = 1'b1; rs_pol = 1'b0; idle(4);
      cs_n = 1'b0; idle(4);
      c0 = vld_cnt;
      rs = 1'b1;                         // R9 pin opposite of tag
      clock_bits({1'b0, 8'h5A}, 9); frame_end();
      chk("R4 count 9 bits", vld_cnt - c0, 1);
      chk("R4 byte", cap_byte, 8'h5A);
      chk("R5 pol0 tag0 data", cap_data, 1);
      chk("R9 rs pin ignored", byte_is_data, 1);
      rs = 1'b0;
      clock_bits({1'b1, 8'hC3}, 9); frame_end();
      chk("R5 pol0 tag1 command", cap_data, 0);
      chk("R4 byte tag1", cap_byte, 8'hC3);
      // 8 bits only: no frame yet in 3-wire
      c0 = vld_cnt;
      clock_bits({1'b1, 8'h00}, 8); frame_end();
      chk("R4 no byte after 8 edges", vld_cnt - c0, 0);
      cs_n = 1'b1; idle(6);
      rs_pol = 1'b1; idle(4);
      cs_n = 1'b0; idle(4);
      clock_bits({1'b1, 8'h7E}, 9); frame_end();
      chk("R5 pol1 tag1 data", cap_data, 1);
      clock_bits({1'b0, 8'h81}, 9); frame_end();
      chk("R5 pol1 tag0 command", cap_data, 0);
      chk("R4 byte", cap_byte, 8'h81);
      cs_n = 1'b1; idle(6);
   endtask

   task automatic t_deselect();
      int c0;
      wire3_sel = 1'b0; rs = 1'b1; idle(4);
      c0 = vld_cnt;
      clock_bits(9'h0FF, 8); frame_end();       // cs_n high
      chk("R6 edges ignored when deselected", vld_cnt - c0, 0);
      cs_n = 1'b0; idle(4);
      clock_bits(9'h01F, 5);                    // partial
      cs_n = 1'b1; idle(6);
      chk("R6 partial dropped", vld_cnt - c0, 0);
      chk("R6 byte_out kept", byte_out, 8'h81);
      cs_n = 1'b0; idle(4);
      clock_bits(9'h096, 8); frame_end();
      chk("R6 restart count", vld_cnt - c0, 1);
      chk("R6 restart byte", cap_byte, 8'h96);
      cs_n = 1'b1; idle(6);
   endtask

   task automatic t_back_to_back();
      int c0;
      logic [7:0] vals [3] = '{8'h12, 8'hED, 8'h40};
      wire3_sel = 1'b0; rs = 1'b0; idle(4);
      cs_n = 1'b0; idle(4);
      for (int k = 0; k < 3; k++) begin
         c0 = vld_cnt;
         clock_bits({1'b0, vals[k]}, 8); frame_end();
         chk("R7 frame count", vld_cnt - c0, 1);
         chk("R7 frame byte", cap_byte, vals[k]);
      end
      cs_n = 1'b1; idle(6);
      chk("R8 single-cycle pulses", dbl_vld, 0);
   endtask

   initial begin
      idle(3);
      t_reset();
      rst_n = 1'b1; idle(5);
      t_reset();
      t_four_wire();
      t_three_wire();
      t_deselect();
      t_back_to_back();
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #1ms;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule